// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation-lookaside miss in hardware. It takes a 32-bit virtual address and the base of the translation table. It reads one first-level descriptor through a single-word read port that uses a request/valid handshake. It decodes that word as a 1 MB section, a 16 MB supersection, a pointer to a coarse second-level table, or a fault. When the word is a pointer, the walker reads one more descriptor and decodes it as a 4 KB small page or a 64 KB large page.

A successful walk ends in a one-cycle refill pulse. The pulse carries the physical page base, a page-size code and three attribute fields: endianness, element size and mixed-size select. A walk that fails produces no refill. Instead it sets a sticky translation-fault status bit and captures the faulting virtual address. The status bits are cleared by writing one to them, and the interrupt line is the status masked by an enable vector.

The walker accepts a start request only while the table-walk enable input is high. It has at most one read in flight, and it shows a busy flag for as long as a walk is in progress.

Top module: `ptw_walker`

## Requirements
- R1: While `walk_en` is low, a `walk_start` pulse is ignored: `busy` and `mem_req` stay low.
- R2: The first read goes to `(ttb & 0xFFFFC000) | (va[31:20] << 2)`. The table base therefore loses its low 14 bits before use.
- R3: A first-level word whose bits [1:0] are `10` is a leaf. If bit 18 is set, the leaf is a supersection: size code 3 and base `desc[31:24]` followed by 24 zero bits. Otherwise it is a section: size code 2 and base `desc[31:20]` followed by 20 zero bits. The attributes are endianness from bit 15, element size from bits [11:10] and mixed size from bit 17.
- R4: A first-level word whose bits [1:0] are `01` starts a second read at `(desc & 0xFFFFFC00) | (va[19:12] << 2)`.
- R5: In a second-level word, bit 1 set gives a small page: size code 0 and base `desc[31:12]` followed by 12 zero bits. If bit 1 is clear and bit 0 is set, it gives a large page: size code 1 and base `desc[31:16]` followed by 16 zero bits. The attributes are endianness from bit 9, element size from bits [5:4] and mixed size from bit 11.
- R6: A fault occurs when a first-level word has type `00` or `11`, or when a second-level word has both bit 1 and bit 0 clear. A fault emits no refill, sets `irq_status[1]` and loads `fault_addr` with the walk's virtual address.
- R7: Writing one to bit 1 of `irq_clr` clears `irq_status[1]`. A new fault in the same cycle wins over the clear. `irq` equals the OR of `irq_status & irq_en`.
- R8: `busy` is high from the cycle after an accepted start until the walk ends. Each level raises `mem_req` for exactly one cycle. A `walk_start` that arrives while busy is ignored.
- R9: `refill_valid` is a one-cycle pulse in the cycle after the read return that completes the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_en | input | 1 | Table-walk enable |
| walk_start | input | 1 | Miss request, sampled while idle |
| walk_va | input | 32 | Virtual address to translate |
| ttb | input | 32 | Translation table base |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 32 | Descriptor address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| busy | output | 1 | Walk in progress |
| refill_valid | output | 1 | Result pulse |
| refill_pa | output | 32 | Physical page base |
| refill_size | output | 2 | 0=4KB, 1=64KB, 2=1MB, 3=16MB |
| refill_endian | output | 1 | Endianness attribute |
| refill_elem | output | 2 | Element size attribute |
| refill_mixed | output | 1 | Mixed-size attribute |
| irq_clr | input | 2 | Write-one-to-clear for status bits |
| irq_en | input | 2 | Interrupt enable mask |
| irq_status | output | 2 | Status, bit 1 = translation fault |
| fault_addr | output | 32 | Captured faulting address |
| irq | output | 1 | Masked interrupt |

## Verification
Each result of this walker has a fixed cycle in which it is due. The first request appears one cycle after the start is sampled. The second-level request appears one cycle after the first read returns. A refill appears one cycle after the final read returns. The fault status and captured address are due two cycles after the final return, and a clear takes effect one cycle after the clear pulse. The bench drives every input on the falling edge and samples each output on the falling edge of exactly that cycle, so a result that arrives late or early fails the check. The sweep covers all four first-level type codes with both values of bit 18, and all four second-level type codes behind a coarse pointer, across several addresses and bases.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W         = 32;
    localparam int TTB_ALIGN_BITS = 14;
    localparam int L1_IDX_LSB     = 20;
    localparam int L2_IDX_LSB     = 12;
    localparam int L2_IDX_W       = L1_IDX_LSB - L2_IDX_LSB;
    localparam int COARSE_LSB     = 10;
    localparam int IRQ_W          = 2;
    localparam int FAULT_BIT      = 1;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        K_FAULT  = 2'd0,
        K_COARSE = 2'd1,
        K_LEAF   = 2'd2
    } desc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pa_base;
        pg_size_e          size;
        logic              endian;
        logic [1:0]        elem;
        logic              mixed;
    } xlat_t;

    function automatic logic [ADDR_W-1:0] page_mask(input pg_size_e sz);
        case (sz)
            PG_4K:   page_mask = {{(ADDR_W-12){1'b1}}, 12'd0};
            PG_64K:  page_mask = {{(ADDR_W-16){1'b1}}, 16'd0};
            PG_1M:   page_mask = {{(ADDR_W-20){1'b1}}, 20'd0};
            default: page_mask = {{(ADDR_W-24){1'b1}}, 24'd0};
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] l1_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] va);
        logic [ADDR_W-1:0] aligned;
        aligned = base & {{(ADDR_W-TTB_ALIGN_BITS){1'b1}}, {TTB_ALIGN_BITS{1'b0}}};
        l1_addr = aligned | {{(L1_IDX_LSB-2){1'b0}}, va[ADDR_W-1:L1_IDX_LSB], 2'b00};
    endfunction

    function automatic logic [ADDR_W-1:0] l2_addr(input logic [ADDR_W-1:0] desc,
                                                  input logic [ADDR_W-1:0] va);
        logic [ADDR_W-1:0] cbase;
        cbase = desc & {{(ADDR_W-COARSE_LSB){1'b1}}, {COARSE_LSB{1'b0}}};
        l2_addr = cbase | {{(ADDR_W-L2_IDX_W-2){1'b0}}, va[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
    endfunction

endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [ADDR_W-1:0] desc,
    output desc_kind_e        kind,
    output xlat_t             xl
);

    generate
        if (LEVEL == 1) begin : g_first
            always_comb begin
                xl        = '0;
                kind      = K_FAULT;
                xl.size   = desc[18] ? PG_16M : PG_1M;
                xl.endian = desc[15];
                xl.elem   = desc[11:10];
                xl.mixed  = desc[17];
                xl.pa_base = desc & page_mask(xl.size);
                case (desc[1:0])
                    2'b01:   kind = K_COARSE;
                    2'b10:   kind = K_LEAF;
                    default: kind = K_FAULT;
                endcase
            end
        end else begin : g_second
            always_comb begin
                xl        = '0;
                xl.size   = desc[1] ? PG_4K : PG_64K;
                xl.endian = desc[9];
                xl.elem   = desc[5:4];
                xl.mixed  = desc[11];
                xl.pa_base = desc & page_mask(xl.size);
                kind      = (desc[1] || desc[0]) ? K_LEAF : K_FAULT;
            end
        end
    endgenerate

endmodule

// File: rtl/ptw_fault_status.sv
module ptw_fault_status
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_set,
    input  logic [ADDR_W-1:0] fault_va,
    input  logic [IRQ_W-1:0]  clr,
    input  logic [IRQ_W-1:0]  en,
    output logic [IRQ_W-1:0]  status,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              irq
);

    logic [IRQ_W-1:0] set_vec;

    always_comb begin
        set_vec            = '0;
        set_vec[FAULT_BIT] = fault_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status     <= '0;
            fault_addr <= '0;
        end else begin
            status <= (status & ~clr) | set_vec;
            if (fault_set) fault_addr <= fault_va;
        end
    end

    assign irq = |(status & en);

    a_r6_fault_latched: assert property (@(posedge clk) disable iff (rst)
        fault_set |=> (status[FAULT_BIT] && fault_addr == $past(fault_va)));

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (clr[FAULT_BIT] && !fault_set) |=> !status[FAULT_BIT]);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (!clr[FAULT_BIT] && !fault_set) |=> $stable(status[FAULT_BIT]));

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        walk_en,
    input  logic        walk_start,
    input  logic [31:0] walk_va,
    input  logic [31:0] ttb,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        busy,
    output logic        refill_valid,
    output logic [31:0] refill_pa,
    output logic [1:0]  refill_size,
    output logic        refill_endian,
    output logic [1:0]  refill_elem,
    output logic        refill_mixed,
    input  logic [1:0]  irq_clr,
    input  logic [1:0]  irq_en,
    output logic [1:0]  irq_status,
    output logic [31:0] fault_addr,
    output logic        irq
);

    walk_state_e       state_q;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] addr_q;
    xlat_t             res_q;

    desc_kind_e l1_kind, l2_kind;
    xlat_t      l1_xl, l2_xl;

    ptw_desc_decode #(.LEVEL(1)) u_dec_l1 (.desc(mem_rdata), .kind(l1_kind), .xl(l1_xl));
    ptw_desc_decode #(.LEVEL(2)) u_dec_l2 (.desc(mem_rdata), .kind(l2_kind), .xl(l2_xl));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            addr_q  <= '0;
            res_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (walk_start && walk_en) begin
                    va_q    <= walk_va;
                    addr_q  <= l1_addr(ttb, walk_va);
                    state_q <= ST_L1_REQ;
                end
                ST_L1_REQ: state_q <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rvalid) begin
                    case (l1_kind)
                        K_LEAF: begin
                            res_q   <= l1_xl;
                            state_q <= ST_DONE;
                        end
                        K_COARSE: begin
                            addr_q  <= l2_addr(mem_rdata, va_q);
                            state_q <= ST_L2_REQ;
                        end
                        default: state_q <= ST_FAULT;
                    endcase
                end
                ST_L2_REQ: state_q <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rvalid) begin
                    if (l2_kind == K_LEAF) begin
                        res_q   <= l2_xl;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_FAULT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req       = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign mem_addr      = addr_q;
    assign busy          = (state_q != ST_IDLE);
    assign refill_valid  = (state_q == ST_DONE);
    assign refill_pa     = res_q.pa_base;
    assign refill_size   = res_q.size;
    assign refill_endian = res_q.endian;
    assign refill_elem   = res_q.elem;
    assign refill_mixed  = res_q.mixed;

    ptw_fault_status u_status (
        .clk       (clk),
        .rst       (rst),
        .fault_set (state_q == ST_FAULT),
        .fault_va  (va_q),
        .clr       (irq_clr),
        .en        (irq_en),
        .status    (irq_status),
        .fault_addr(fault_addr),
        .irq       (irq)
    );

    a_r1_disabled_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !walk_en) |=> !busy);

    a_r8_req_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    a_r9_refill_after_return: assert property (@(posedge clk) disable iff (rst)
        refill_valid |-> $past(mem_rvalid));

    a_r3_base_aligned: assert property (@(posedge clk) disable iff (rst)
        refill_valid |-> ((refill_pa & ~page_mask(pg_size_e'(refill_size))) == '0));

endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        walk_en = 1'b0, walk_start = 1'b0;
    logic [31:0] walk_va = '0, ttb = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, refill_valid, refill_endian, refill_mixed, irq;
    logic [31:0] refill_pa, fault_addr;
    logic [1:0]  refill_size, refill_elem, irq_status;
    logic [1:0]  irq_clr = '0, irq_en = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst(rst), .walk_en(walk_en), .walk_start(walk_start),
        .walk_va(walk_va), .ttb(ttb), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
        .refill_valid(refill_valid), .refill_pa(refill_pa), .refill_size(refill_size),
        .refill_endian(refill_endian), .refill_elem(refill_elem), .refill_mixed(refill_mixed),
        .irq_clr(irq_clr), .irq_en(irq_en), .irq_status(irq_status),
        .fault_addr(fault_addr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                            input logic [31:0] d1, input logic [31:0] d2,
                            input logic poke_busy);
        logic [31:0] e_l1, e_l2, e_pa;
        logic [1:0]  e_sz, e_elm;
        logic        e_end, e_mix, leaf, two;
        e_l1 = (base & 32'hFFFF_C000) | {20'd0, va[31:20], 2'b00};
        e_l2 = '0; e_pa = '0; e_sz = '0; e_elm = '0; e_end = 0; e_mix = 0;
        leaf = 0;
        two  = (d1[1:0] == 2'b01);
        if (d1[1:0] == 2'b10) begin
            leaf = 1;
            if (d1[18]) begin e_pa = {d1[31:24], 24'd0}; e_sz = 2'd3; end
            else        begin e_pa = {d1[31:20], 20'd0}; e_sz = 2'd2; end
            e_end = d1[15]; e_elm = d1[11:10]; e_mix = d1[17];
        end else if (two) begin
            e_l2 = {d1[31:10], 10'd0} | {22'd0, va[19:12], 2'b00};
            if (d2[1])      begin leaf = 1; e_pa = {d2[31:12], 12'd0}; e_sz = 2'd0; end
            else if (d2[0]) begin leaf = 1; e_pa = {d2[31:16], 16'd0}; e_sz = 2'd1; end
            e_end = d2[9]; e_elm = d2[5:4]; e_mix = d2[11];
        end

        @(negedge clk);
        walk_va = va; ttb = base; walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        chk("R8 busy after start", {39'd0, busy}, 40'd1);
        chk("R8 first request", {39'd0, mem_req}, 40'd1);
        chk("R2 first address", {8'd0, mem_addr}, {8'd0, e_l1});
        @(negedge clk);
        chk("R8 request single cycle", {39'd0, mem_req}, 40'd0);
        if (poke_busy) begin
            walk_start = 1'b1; walk_va = ~va;
        end
        mem_rvalid = 1'b1; mem_rdata = d1;
        @(negedge clk);
        walk_start = 1'b0;
        mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        if (two) begin
            chk("R4 second request", {39'd0, mem_req}, 40'd1);
            chk("R4 second address", {8'd0, mem_addr}, {8'd0, e_l2});
            @(negedge clk);
            chk("R8 second request single cycle", {39'd0, mem_req}, 40'd0);
            mem_rvalid = 1'b1; mem_rdata = d2;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        end
        if (leaf) begin
            chk(two ? "R9 R5 refill pulse" : "R9 R3 refill pulse", {39'd0, refill_valid}, 40'd1);
            chk(two ? "R5 page base" : "R3 page base", {8'd0, refill_pa}, {8'd0, e_pa});
            chk(two ? "R5 size/attrs" : "R3 size/attrs",
                {34'd0, refill_size, refill_endian, refill_elem, refill_mixed},
                {34'd0, e_sz, e_end, e_elm, e_mix});
            @(negedge clk);
            chk("R9 refill one cycle", {39'd0, refill_valid}, 40'd0);
            chk("R8 idle after walk", {39'd0, busy}, 40'd0);
            chk("R6 no fault on leaf", {38'd0, irq_status}, 40'd0);
        end else begin
            chk("R6 no refill on fault", {39'd0, refill_valid}, 40'd0);
            @(negedge clk);
            chk("R6 fault status", {38'd0, irq_status}, 40'd2);
            chk("R6 fault address", {8'd0, fault_addr}, {8'd0, va});
            chk("R6 still no refill", {39'd0, refill_valid}, 40'd0);
            chk("R8 idle after fault", {39'd0, busy}, 40'd0);
            chk("R7 irq masked", {39'd0, irq}, {39'd0, irq_en[1]});
            irq_clr = 2'b10;
            @(negedge clk);
            irq_clr = 2'b00;
            chk("R7 w1c clear", {38'd0, irq_status}, 40'd0);
            chk("R7 irq after clear", {39'd0, irq}, 40'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] vas [3];
        logic [31:0] bases [3];
        vas[0] = 32'h0000_0000; vas[1] = 32'hFFFF_FFFF; vas[2] = 32'h9ABC_D123;
        bases[0] = 32'h8000_0000; bases[1] = 32'h1234_7FFF; bases[2] = 32'hFFFF_FFFF;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8 reset busy", {39'd0, busy}, 40'd0);
        chk("R8 reset request", {39'd0, mem_req}, 40'd0);
        chk("R9 reset refill", {39'd0, refill_valid}, 40'd0);
        chk("R6 reset status", {38'd0, irq_status}, 40'd0);
        chk("R6 reset fault address", {8'd0, fault_addr}, 40'd0);
        chk("R7 reset irq", {39'd0, irq}, 40'd0);

        walk_va = 32'h1111_1111; walk_start = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R1 disabled no request", {39'd0, mem_req}, 40'd0);
            chk("R1 disabled not busy", {39'd0, busy}, 40'd0);
        end
        walk_start = 1'b0;
        walk_en = 1'b1;

        for (int v = 0; v < 3; v++) begin
            irq_en = (v == 1) ? 2'b00 : 2'b10;
            for (int t1 = 0; t1 < 4; t1++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [31:0] d1;
                    d1 = 32'hA5C3_9E70 ^ (32'h0103_0507 * (v*8 + t1*2 + b + 1));
                    d1[1:0] = t1[1:0];
                    d1[18]  = b[0];
                    if (t1 == 1) begin
                        for (int t2 = 0; t2 < 4; t2++) begin
                            logic [31:0] d2;
                            d2 = 32'h5A3C_6B8D ^ (32'h0907_0503 * (t2 + 4*b + 1));
                            d2[1:0] = t2[1:0];
                            run_walk(vas[v], bases[v], d1, d2, 1'b0);
                        end
                    end else begin
                        run_walk(vas[v], bases[v], d1, 32'h0, 1'b0);
                    end
                end
            end
        end

        run_walk(32'h4567_89AB, 32'h0000_4000, 32'h0000_0000, 32'h0, 1'b1);
        chk("R8 start during busy ignored", {39'd0, busy}, 40'd0);

        irq_en = 2'b10;
        begin
            @(negedge clk);
            walk_va = 32'h0BAD_F00D; walk_start = 1'b1;
            @(negedge clk);
            walk_start = 1'b0;
            @(negedge clk);
            mem_rvalid = 1'b1; mem_rdata = 32'h0000_0003;
            @(negedge clk);
            mem_rvalid = 1'b0;
            irq_clr = 2'b10;
            @(negedge clk);
            irq_clr = 2'b00;
            chk("R7 set wins over clear", {38'd0, irq_status}, 40'd2);
            chk("R7 irq with enable", {39'd0, irq}, 40'd1);
            irq_clr = 2'b10;
            @(negedge clk);
            irq_clr = 2'b00;
            chk("R7 cleared after", {38'd0, irq_status}, 40'd0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule